// File: doc/BRIEF.md
# Frame Deadline Regulator With Load Smoothing

This block is a per-frame controller for a video decoding pipeline. It sits above a fast speed controller. Each time a frame finishes decoding, the block receives the completion time and the measured instruction count of that frame. From these it produces two set-points for the next frame: a requested deadline and an estimate of the instruction load. The speed controller uses both to choose its voltage and frequency levels.

The block keeps an ideal schedule whose slots are one frame period apart. It measures how late or early each frame finished against its slot. The next requested deadline is the next ideal slot plus a scaled fraction of that error, so lateness decays geometrically and is neither reset nor accumulated. The load estimate is a first-order low-pass filter of the measured loads. Both gains are unsigned fixed point with 8 fraction bits and are held in registers that can be written.

The block also reads a decode-ahead buffer occupancy of up to three frames and the type of the next frame. From these and the error it raises overload actions in rising order of quality impact. Quality layers are truncated first. The optional post-filter is dropped next. A frame is skipped only as a last step. Times are in microsecond ticks.

Top module: `fdr_regulator`

## Requirements
- R1: After reset `out_valid` is low and every output is zero. The effective gains are alpha = 26 and beta = 77, which is 0.1 and 0.3 in 1/256 units.
- R2: The ideal slot of the first frame after reset is PERIOD_US (default 40000), and each later slot is one PERIOD_US after the one before. `dl_error` is the signed value `done_time` minus the current slot.
- R3: `req_deadline` is the next ideal slot plus round(beta × error / 256). Rounding goes to nearest, and an exact half rounds toward plus infinity.
- R4: When the value from R3 is earlier than `done_time`, `req_deadline` equals `done_time`.
- R5: `load_est` is round((alpha × previous estimate + (256 − alpha) × `meas_load`) / 256), with the same rounding as R3. The estimate starts at 0.
- R6: With alpha = 0 the filter is bypassed, so `load_est` equals the last `meas_load` exactly.
- R7: A `gain_wr` pulse loads `alpha_in` and `beta_in`. A beta of 0 is stored as 1, and a beta above 256 is stored as 256. A frame strobe in the same cycle as a write uses the gains from before the write.
- R8: All outputs change only on the clock edge that samples `frame_done`, so they are visible one cycle after the strobe. They then hold until the next strobe. `out_valid` rises with the first strobe and stays high.
- R9: `trunc_layers` is set exactly when the error is greater than zero and the next frame type is not I. The type encoding is 0 = I, 1 = P, 2 = B, and 3 is treated as B.
- R10: `drop_filter` is set exactly when the error is greater than zero and `buf_occ` is 2 or more.
- R11: `skip_frame` is set only when `buf_occ` is 3. For a P or B frame the error must also exceed PERIOD_US. For an I frame the error must exceed 2 × PERIOD_US.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gain_wr | input | 1 | Write strobe for the gain registers |
| alpha_in | input | 8 | Smoothing gain, 1/256 units |
| beta_in | input | 9 | Error gain, 1/256 units, clamped to 1..256 |
| frame_done | input | 1 | One-cycle pulse when a frame finishes decoding |
| done_time | input | 32 | Completion time of the finished frame, microsecond ticks |
| meas_load | input | 24 | Measured instruction count of the finished frame |
| buf_occ | input | 2 | Frames waiting in the decode-ahead buffer, 0..3 |
| frame_type | input | 2 | Type of the next frame: 0 I, 1 P, 2 B, 3 B |
| req_deadline | output | 32 | Requested deadline of the next frame |
| load_est | output | 24 | Load estimate for the next frame |
| dl_error | output | 33 | Signed deadline error of the finished frame |
| out_valid | output | 1 | High once a first frame has been processed |
| trunc_layers | output | 1 | Truncate quality layers of the next frame |
| drop_filter | output | 1 | Drop the optional post-filter |
| skip_frame | output | 1 | Skip the next frame |

## Verification
A gain register write and a frame-completion strobe can land on the same clock edge. The design must then use the old gains for that frame and the new gains only from the next one. The bench forces this collision with directed writes that change alpha and beta sharply, for example to a bypass alpha of 0 and a full beta of 256, and also as random events within the stream of frames. It judges each case against a reference model whose gains change only after the frame result has been computed, so any early use of the new gains shows up as a mismatch in the deadline or the load estimate. The overload flags in the same cycle are checked against the escalation rules for the sampled occupancy and frame type.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
  typedef enum logic [1:0] {
    FT_I = 2'd0,
    FT_P = 2'd1,
    FT_B = 2'd2,
    FT_X = 2'd3
  } ftype_e;

  localparam logic [7:0] ALPHA_RST = 8'd26;
  localparam logic [8:0] BETA_RST  = 9'd77;
endpackage

// File: rtl/fdr_deadline.sv
module fdr_deadline #(
  parameter int TW     = 32,
  parameter int GW     = 9,
  parameter int PERIOD = 40000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe,
  input  logic [TW-1:0]        done_time,
  input  logic [GW-1:0]        beta,
  output logic signed [TW:0]   err_now,
  output logic signed [TW:0]   err_q,
  output logic [TW-1:0]        req_q
);
  localparam int EW = TW + 1;
  localparam int PW = EW + GW + 1;
  localparam int RW = TW + 2;
  localparam logic [TW-1:0] STEP = TW'(PERIOD);

  function automatic logic signed [EW-1:0] scale_round(
    input logic signed [EW-1:0] e, input logic [GW-1:0] g);
    logic signed [PW-1:0] p;
    p = PW'(e) * $signed({1'b0, g});
    p = p + PW'(128);
    return EW'(p >>> 8);
  endfunction

  logic [TW-1:0]        slot_q;
  logic [TW-1:0]        slot_next;
  logic signed [EW-1:0] corr;
  logic signed [RW-1:0] cand;
  logic signed [RW-1:0] now_s;
  logic                 clamp_hit;
  logic [TW-1:0]        req_next;

  always_comb begin
    err_now   = $signed({1'b0, done_time}) - $signed({1'b0, slot_q});
    slot_next = slot_q + STEP;
    corr      = scale_round(err_now, beta);
    cand      = $signed({2'b00, slot_next}) + RW'(corr);
    now_s     = $signed({2'b00, done_time});
    clamp_hit = cand < now_s;
    req_next  = clamp_hit ? done_time : cand[TW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= STEP;
      req_q  <= '0;
      err_q  <= '0;
    end else if (strobe) begin
      slot_q <= slot_next;
      req_q  <= req_next;
      err_q  <= err_now;
    end
  end

  p_not_before_now_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> req_q >= $past(done_time));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(req_q) && $stable(err_q)));

  p_err_sampled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> err_q == $past(err_now));
endmodule

// File: rtl/fdr_smooth.sv
module fdr_smooth #(
  parameter int LW = 24,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [LW-1:0] meas,
  input  logic [AW-1:0] alpha,
  output logic [LW-1:0] est_q
);
  localparam int AccW = LW + AW + 1;
  typedef logic [AccW-1:0] acc_t;
  localparam acc_t ONE  = acc_t'(1) << AW;
  localparam acc_t HALF = acc_t'(1) << (AW - 1);

  function automatic logic [LW-1:0] blend(
    input logic [LW-1:0] prev, input logic [LW-1:0] m, input logic [AW-1:0] a);
    acc_t acc;
    acc = acc_t'(prev) * acc_t'(a) + acc_t'(m) * (ONE - acc_t'(a)) + HALF;
    return acc[AW +: LW];
  endfunction

  logic [LW-1:0] est_next;

  always_comb est_next = blend(est_q, meas, alpha);

  always_ff @(posedge clk) begin
    if (!rst_n)      est_q <= '0;
    else if (strobe) est_q <= est_next;
  end

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && alpha == '0) |=> est_q == $past(meas));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(est_q));
endmodule

// File: rtl/fdr_escalate.sv
module fdr_escalate #(
  parameter int EW     = 33,
  parameter int PERIOD = 40000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe,
  input  logic signed [EW-1:0] err_now,
  input  logic [1:0]           occ,
  input  logic [1:0]           ftype,
  output logic                 trunc_q,
  output logic                 nopf_q,
  output logic                 skip_q
);
  import fdr_pkg::*;

  localparam logic signed [EW-1:0] LIM_PB = EW'(PERIOD);
  localparam logic signed [EW-1:0] LIM_I  = EW'(2 * PERIOD);

  logic is_i, late, trunc_n, nopf_n, skip_n;

  always_comb begin
    is_i    = ftype == FT_I;
    late    = err_now > 0;
    trunc_n = late && !is_i;
    nopf_n  = late && (occ >= 2'd2);
    skip_n  = (occ == 2'd3) && (is_i ? (err_now > LIM_I) : (err_now > LIM_PB));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trunc_q <= 1'b0;
      nopf_q  <= 1'b0;
      skip_q  <= 1'b0;
    end else if (strobe) begin
      trunc_q <= trunc_n;
      nopf_q  <= nopf_n;
      skip_q  <= skip_n;
    end
  end

  p_skip_after_filter_r11: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |-> nopf_q);

  p_i_keeps_layers_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && ftype == FT_I) |=> !trunc_q);

  p_pb_skip_after_trunc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && ftype != FT_I) |=> (!skip_q || trunc_q));

  p_skip_full_buffer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && occ != 2'd3) |=> !skip_q);
endmodule

// File: rtl/fdr_regulator.sv
module fdr_regulator #(
  parameter int TW        = 32,
  parameter int LW        = 24,
  parameter int AW        = 8,
  parameter int PERIOD_US = 40000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gain_wr,
  input  logic [AW-1:0]       alpha_in,
  input  logic [AW:0]         beta_in,
  input  logic                frame_done,
  input  logic [TW-1:0]       done_time,
  input  logic [LW-1:0]       meas_load,
  input  logic [1:0]          buf_occ,
  input  logic [1:0]          frame_type,
  output logic [TW-1:0]       req_deadline,
  output logic [LW-1:0]       load_est,
  output logic signed [TW:0]  dl_error,
  output logic                out_valid,
  output logic                trunc_layers,
  output logic                drop_filter,
  output logic                skip_frame
);
  import fdr_pkg::*;

  localparam int GW = AW + 1;
  localparam logic [GW-1:0] BETA_MAX = GW'(1) << AW;

  logic [AW-1:0]     alpha_q;
  logic [GW-1:0]     beta_q;
  logic [GW-1:0]     beta_wr_val;
  logic signed [TW:0] err_now;

  always_comb begin
    if (beta_in == '0)           beta_wr_val = GW'(1);
    else if (beta_in > BETA_MAX) beta_wr_val = BETA_MAX;
    else                         beta_wr_val = beta_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alpha_q <= AW'(ALPHA_RST);
      beta_q  <= GW'(BETA_RST);
    end else if (gain_wr) begin
      alpha_q <= alpha_in;
      beta_q  <= beta_wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          out_valid <= 1'b0;
    else if (frame_done) out_valid <= 1'b1;
  end

  fdr_deadline #(.TW(TW), .GW(GW), .PERIOD(PERIOD_US)) u_deadline (
    .clk(clk), .rst_n(rst_n), .strobe(frame_done), .done_time(done_time),
    .beta(beta_q), .err_now(err_now), .err_q(dl_error), .req_q(req_deadline)
  );

  fdr_smooth #(.LW(LW), .AW(AW)) u_smooth (
    .clk(clk), .rst_n(rst_n), .strobe(frame_done), .meas(meas_load),
    .alpha(alpha_q), .est_q(load_est)
  );

  fdr_escalate #(.EW(TW + 1), .PERIOD(PERIOD_US)) u_escalate (
    .clk(clk), .rst_n(rst_n), .strobe(frame_done), .err_now(err_now),
    .occ(buf_occ), .ftype(frame_type), .trunc_q(trunc_layers),
    .nopf_q(drop_filter), .skip_q(skip_frame)
  );

  p_beta_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beta_q != '0) && (beta_q <= BETA_MAX));

  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  p_valid_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frame_done));

  p_gain_old_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_wr |=> ($stable(alpha_q) && $stable(beta_q)));
endmodule

// File: tb/test_fdr_regulator.sv
module test_fdr_regulator;
  localparam longint P = 40000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gain_wr = 1'b0;
  logic [7:0]  alpha_in = '0;
  logic [8:0]  beta_in = '0;
  logic        frame_done = 1'b0;
  logic [31:0] done_time = '0;
  logic [23:0] meas_load = '0;
  logic [1:0]  buf_occ = '0;
  logic [1:0]  frame_type = '0;
  logic [31:0] req_deadline;
  logic [23:0] load_est;
  logic signed [32:0] dl_error;
  logic        out_valid, trunc_layers, drop_filter, skip_frame;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  longint m_slot = P;
  longint m_est = 0;
  longint m_alpha = 26;
  longint m_beta = 77;
  longint e_req = 0, e_err = 0;
  bit e_tr = 0, e_pf = 0, e_sk = 0;

  always #2.5 clk = ~clk;

  fdr_regulator i_fdr_regulator (
    .clk(clk), .rst_n(rst_n), .gain_wr(gain_wr), .alpha_in(alpha_in),
    .beta_in(beta_in), .frame_done(frame_done), .done_time(done_time),
    .meas_load(meas_load), .buf_occ(buf_occ), .frame_type(frame_type),
    .req_deadline(req_deadline), .load_est(load_est), .dl_error(dl_error),
    .out_valid(out_valid), .trunc_layers(trunc_layers),
    .drop_filter(drop_filter), .skip_frame(skip_frame)
  );

  function automatic longint rnd_half_up(real x);
    return longint'($rtoi($floor(x + 0.5)));
  endfunction

  function automatic longint beta_store(longint b);
    if (b == 0) return 1;
    if (b > 256) return 256;
    return b;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    chk({ctx, " R3/R4 req"}, longint'(req_deadline), e_req);
    chk({ctx, " R5 est"}, longint'(load_est), m_est);
    chk({ctx, " R2 err"}, longint'(dl_error), e_err);
    chk({ctx, " R8 valid"}, longint'(out_valid), 1);
    chk({ctx, " R9 trunc"}, longint'(trunc_layers), longint'(e_tr));
    chk({ctx, " R10 filter"}, longint'(drop_filter), longint'(e_pf));
    chk({ctx, " R11 skip"}, longint'(skip_frame), longint'(e_sk));
  endtask

  // model one finished frame (old gains apply), then optionally update gains
  task automatic frame(longint t, longint ld, int occ, int ft,
                       bit wr, longint a, longint b, string ctx);
    longint corr;
    @(negedge clk);
    done_time = 32'(t); meas_load = 24'(ld);
    buf_occ = 2'(occ); frame_type = 2'(ft);
    frame_done = 1'b1;
    gain_wr = wr; alpha_in = 8'(a); beta_in = 9'(b);
    e_err = t - m_slot;
    corr = rnd_half_up(real'(m_beta * e_err) / 256.0);
    e_req = m_slot + P + corr;
    if (e_req < t) e_req = t;
    m_slot = m_slot + P;
    m_est = rnd_half_up(real'(m_alpha * m_est + (256 - m_alpha) * ld) / 256.0);
    e_tr = (e_err > 0) && (ft != 0);
    e_pf = (e_err > 0) && (occ >= 2);
    e_sk = (occ == 3) && ((ft == 0) ? (e_err > 2 * P) : (e_err > P));
    if (wr) begin m_alpha = a; m_beta = beta_store(b); end
    @(negedge clk);
    frame_done = 1'b0; gain_wr = 1'b0;
    check_all(ctx);
  endtask

  task automatic set_gains(longint a, longint b);
    @(negedge clk);
    gain_wr = 1'b1; alpha_in = 8'(a); beta_in = 9'(b);
    @(negedge clk);
    gain_wr = 1'b0;
    m_alpha = a; m_beta = beta_store(b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", longint'(out_valid), 0);
    chk("R1 req", longint'(req_deadline), 0);
    chk("R1 est", longint'(load_est), 0);
    chk("R1 flags", longint'({trunc_layers, drop_filter, skip_frame}), 0);

    // R2/R3 on-time frame with default gains (R1 gains)
    frame(40000, 1000, 0, 1, 0, 0, 0, "ontime");
    chk("R3 ontime req", longint'(req_deadline), 80000);
    chk("R1 default alpha est", longint'(load_est), 898);
    // early frame, negative error, rounding (R3)
    frame(79000, 1000, 1, 2, 0, 0, 0, "early");
    // R4 very late frame: clamp to now
    frame(220000, 5000, 1, 1, 0, 0, 0, "clamp");
    chk("R4 clamp", longint'(req_deadline), 220000);
    // R8 hold across idle cycles
    repeat (4) @(negedge clk);
    chk("R8 hold req", longint'(req_deadline), e_req);
    chk("R8 hold est", longint'(load_est), m_est);
    // R6 bypass and R7 beta clamp to 256
    set_gains(0, 400);
    frame(160000 + 3000, 7777, 0, 1, 0, 0, 0, "bypass");
    chk("R6 bypass est", longint'(load_est), 7777);
    chk("R7 beta 256 req", longint'(req_deadline), 203000);
    // R7 same-cycle write: old alpha 0 used, new alpha 128 later
    frame(200000, 1234, 0, 1, 1, 128, 0, "collide");
    chk("R7 collide old alpha", longint'(load_est), 1234);
    frame(240000, 4000, 0, 1, 0, 0, 0, "after");
    chk("R7 new alpha", longint'(load_est), 2617);
    set_gains(26, 77);
    // R11 I frame: error between 1 and 2 periods, full buffer -> no skip
    frame(280000 + 60000, 900, 3, 0, 0, 0, 0, "i_mid");
    chk("R11 I no skip", longint'(skip_frame), 0);
    chk("R9 I no trunc", longint'(trunc_layers), 0);
    // R11 P frame beyond one period, full buffer -> skip
    frame(320000 + 50000, 900, 3, 1, 0, 0, 0, "p_skip");
    chk("R11 P skip", longint'(skip_frame), 1);
    // R11 I frame beyond two periods -> skip
    frame(360000 + 90000, 900, 3, 0, 0, 0, 0, "i_skip");
    chk("R11 I skip", longint'(skip_frame), 1);
    // R10 boundary: zero error, full buffer -> nothing
    frame(400000, 900, 3, 2, 0, 0, 0, "zero_err");
    chk("R10 zero err filter", longint'(drop_filter), 0);

    // constrained random frames
    for (int k = 0; k < 400; k++) begin
      longint off, ld, a, b;
      bit wr;
      off = longint'($urandom_range(130000)) - 30000;
      ld  = longint'($urandom_range(16000000));
      wr  = ($urandom_range(7) == 0);
      a   = longint'($urandom_range(255));
      b   = longint'($urandom_range(300));
      if ($urandom_range(3) == 0) a = 0;
      frame(m_slot + off, ld, int'($urandom_range(3)), int'($urandom_range(3)),
            wr, a, b, "random");
      if ($urandom_range(4) == 0) set_gains(longint'($urandom_range(255)),
                                            longint'($urandom_range(300)));
      repeat ($urandom_range(2)) @(negedge clk);
      chk("random R8 hold", longint'(req_deadline), e_req);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule